// File: doc/BRIEF.md
# AXI Handshake Dependency Checker

A passive observer for one AXI4 link. It watches the VALID and READY signals of the five channels, plus the final-beat marker of the write data channel. It reports protocol faults that lead to a hung bus. The block drives nothing on the link. It turns what it sees into sticky error flags that a test environment or an on-chip debug path can read and clear.

The checker looks for three kinds of fault:

- **Dropped VALID.** A channel lowers VALID after a cycle in which it was offered but not taken.
- **Early write response.** A write response is shown before both of these have been accepted: its address, and the last beat of its data.
- **Stall.** A channel keeps VALID high and READY low for more consecutive cycles than a programmable limit. The stall flags name the channel that hung, which helps locate deadlocks where two channels wait on each other.

Write data may come before or after its address; neither order is an error.

Top module: `hs_dep_monitor`

## Requirements
- R1: A channel that shows VALID high and READY low in one cycle, then VALID low in the next cycle, sets its bit of `dropErr` at the end of that second cycle. The bit order is AW=0, W=1, B=2, AR=3, R=4. VALID falling in the cycle after a completed handshake (VALID and READY both high) sets nothing.
- R2: In any cycle where `bValid` is high, `earlyRespErr` is set if either of two counts is zero. The first count is AW handshakes not yet answered by a B handshake. The second count is WLAST beats accepted and not yet answered. Both counts are taken from earlier cycles only, so an AW handshake in the same cycle as `bValid` does not make that `bValid` legal.
- R3: W beats may complete before their AW handshake without any flag. Only a W handshake with `wLast` high adds to the data count.
- R4: A B handshake removes one from each nonzero count. When AW, WLAST and B handshakes fall in the same cycle, both counts stay unchanged.
- R5: Each channel has a counter of consecutive cycles with VALID high and READY low. The counter returns to zero on any cycle where VALID is low or a handshake completes. The channel's bit of `stallFlag` is set once the channel has stalled for more than `stallLimit` consecutive cycles.
- R6: Both outstanding counts are 4 bits wide. An increment while a count is at 15, without a matching decrement, sets `overflowErr` and holds the count at 15 instead of wrapping.
- R7: All error and stall flags are sticky. With `clearErr` high, they clear at the next clock edge. An error detected in that same cycle still leaves its flag set.
- R8: `anyErr` is high exactly when at least one error or stall flag is set.
- R9: While `rstN` is low, all flags and counters are held at zero and link activity is not checked or counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| clearErr | input | 1 | Clears all sticky flags |
| stallLimit | input | 16 | Allowed consecutive stall cycles per channel |
| awValid | input | 1 | Write address VALID |
| awReady | input | 1 | Write address READY |
| wValid | input | 1 | Write data VALID |
| wReady | input | 1 | Write data READY |
| wLast | input | 1 | Final write data beat marker |
| bValid | input | 1 | Write response VALID |
| bReady | input | 1 | Write response READY |
| arValid | input | 1 | Read address VALID |
| arReady | input | 1 | Read address READY |
| rValid | input | 1 | Read data VALID |
| rReady | input | 1 | Read data READY |
| dropErr | output | 5 | Per-channel dropped-VALID flags |
| earlyRespErr | output | 1 | Write response seen too early |
| stallFlag | output | 5 | Per-channel stall flags |
| overflowErr | output | 1 | Outstanding count overflow |
| anyErr | output | 1 | OR of all flags |

## Verification
The two functions that can fall in the same cycle are the outstanding-count increments, from AW and WLAST handshakes, and the decrement from a B handshake. The bench first builds one outstanding write. It then completes an AW handshake, a WLAST beat and a B handshake together in one cycle. A correct design must leave both counts at one after that cycle. This is judged through the ports: the next B response must pass without a flag, and the one after it must set `earlyRespErr`. A second coincidence, a flag being cleared in the same cycle a new dropped VALID is detected, is provoked the same way and must leave the flag set.

// File: rtl/hsmon_pkg.sv
package hsmon_pkg;
  localparam int NCH   = 5;
  localparam int IX_AW = 0;
  localparam int IX_W  = 1;
  localparam int IX_B  = 2;
  localparam int IX_AR = 3;
  localparam int IX_R  = 4;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic [NCH-1:0] drop;   // VALID fell while still pending
    logic [NCH-1:0] stall;  // VALID high, READY low this cycle
    logic           awAdd;  // address handshake
    logic           wAdd;   // final data beat handshake
    logic           bTake;  // response handshake
    logic           bSeen;  // response offered
  } strobe_t;
endpackage

// File: rtl/hsmon_ctrl.sv
module hsmon_ctrl
  import hsmon_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic [NCH-1:0] valid,
  input  logic [NCH-1:0] ready,
  input  logic           wLast,
  output strobe_t        strb
);
  logic [NCH-1:0] pendQ;
  logic [NCH-1:0] fire;

  assign fire = valid & ready;

  always_ff @(posedge clk) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= valid & ~ready;
  end

  always_comb begin
    strb.drop  = pendQ & ~valid;
    strb.stall = valid & ~ready;
    strb.awAdd = fire[IX_AW];
    strb.wAdd  = fire[IX_W] & wLast;
    strb.bTake = fire[IX_B];
    strb.bSeen = valid[IX_B];
  end
endmodule

// File: rtl/hsmon_pendcnt.sv
module hsmon_pendcnt #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic inc,
  input  logic dec,
  output logic empty,
  output logic ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic             decOk;

  assign empty = (cnt == '0);
  assign decOk = dec && !empty;
  assign ovf   = inc && !decOk && (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else begin
      unique case ({inc, decOk})
        2'b10:   if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/hsmon_dp.sv
module hsmon_dp
  import hsmon_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int STALL_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clearErr,
  input  logic [STALL_W-1:0] stallLimit,
  input  strobe_t            strb,
  output logic [NCH-1:0]     dropErr,
  output logic               earlyRespErr,
  output logic [NCH-1:0]     stallFlag,
  output logic               overflowErr
);
  localparam logic [STALL_W-1:0] STALL_MAX = {STALL_W{1'b1}};

  logic awEmpty, wEmpty, awOvf, wOvf;
  logic keep;

  assign keep = ~clearErr;

  hsmon_pendcnt #(.CNT_W(CNT_W)) u_awCnt (
    .clk(clk), .rstN(rstN), .inc(strb.awAdd), .dec(strb.bTake),
    .empty(awEmpty), .ovf(awOvf)
  );

  hsmon_pendcnt #(.CNT_W(CNT_W)) u_wCnt (
    .clk(clk), .rstN(rstN), .inc(strb.wAdd), .dec(strb.bTake),
    .empty(wEmpty), .ovf(wOvf)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dropErr      <= '0;
      earlyRespErr <= 1'b0;
      overflowErr  <= 1'b0;
    end else begin
      dropErr      <= (dropErr & {NCH{keep}}) | strb.drop;
      earlyRespErr <= (earlyRespErr & keep) | (strb.bSeen & (awEmpty | wEmpty));
      overflowErr  <= (overflowErr & keep) | awOvf | wOvf;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_stall
    logic [STALL_W-1:0] runLen;
    logic               hit;

    assign hit = strb.stall[c] && (runLen >= stallLimit);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        runLen       <= '0;
        stallFlag[c] <= 1'b0;
      end else begin
        if (!strb.stall[c])          runLen <= '0;
        else if (runLen != STALL_MAX) runLen <= runLen + 1'b1;
        stallFlag[c] <= (stallFlag[c] & keep) | hit;
      end
    end
  end
endmodule

// File: rtl/hs_dep_monitor.sv
module hs_dep_monitor
  import hsmon_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int STALL_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clearErr,
  input  logic [STALL_W-1:0] stallLimit,
  input  logic               awValid,
  input  logic               awReady,
  input  logic               wValid,
  input  logic               wReady,
  input  logic               wLast,
  input  logic               bValid,
  input  logic               bReady,
  input  logic               arValid,
  input  logic               arReady,
  input  logic               rValid,
  input  logic               rReady,
  output logic [4:0]         dropErr,
  output logic               earlyRespErr,
  output logic [4:0]         stallFlag,
  output logic               overflowErr,
  output logic               anyErr
);
  logic [NCH-1:0] validV, readyV;
  strobe_t        strb;

  assign validV = {rValid, arValid, bValid, wValid, awValid};
  assign readyV = {rReady, arReady, bReady, wReady, awReady};

  hsmon_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .valid(validV), .ready(readyV),
    .wLast(wLast), .strb(strb)
  );

  hsmon_dp #(.CNT_W(CNT_W), .STALL_W(STALL_W)) u_dp (
    .clk(clk), .rstN(rstN), .clearErr(clearErr), .stallLimit(stallLimit),
    .strb(strb), .dropErr(dropErr), .earlyRespErr(earlyRespErr),
    .stallFlag(stallFlag), .overflowErr(overflowErr)
  );

  assign anyErr = (|dropErr) | (|stallFlag) | earlyRespErr | overflowErr;
endmodule

// File: rtl/hsmon_chk.sv
module hsmon_chk (
  input logic       clk,
  input logic       rstN,
  input logic       clearErr,
  input logic       awValid, awReady, wValid, wReady, wLast,
  input logic       bValid, bReady, arValid, arReady, rValid, rReady,
  input logic [4:0] dropErr,
  input logic       earlyRespErr,
  input logic [4:0] stallFlag,
  input logic       overflowErr,
  input logic       anyErr
);
  logic [4:0] vV, rV;
  assign vV = {rValid, arValid, bValid, wValid, awValid};
  assign rV = {rReady, arReady, bReady, wReady, awReady};

  for (genvar c = 0; c < 5; c++) begin : g_ch
    assert_drop_flag_R1: assert property (@(posedge clk) disable iff (!rstN)
      (vV[c] && !rV[c]) ##1 !vV[c] |=> dropErr[c]);
    assert_drop_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
      (dropErr[c] && !clearErr) |=> dropErr[c]);
    assert_stall_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
      $rose(stallFlag[c]) |-> $past(vV[c] && !rV[c]));
  end

  assert_early_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(earlyRespErr) |-> $past(bValid));
  assert_ovf_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflowErr) |-> $past((awValid && awReady) || (wValid && wReady && wLast)));
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (overflowErr && !clearErr) |=> overflowErr);
  assert_any_cover_R8: assert property (@(posedge clk) disable iff (!rstN)
    earlyRespErr |-> anyErr);
endmodule

bind hs_dep_monitor hsmon_chk u_chk (
  .clk(clk), .rstN(rstN), .clearErr(clearErr),
  .awValid(awValid), .awReady(awReady), .wValid(wValid), .wReady(wReady), .wLast(wLast),
  .bValid(bValid), .bReady(bReady), .arValid(arValid), .arReady(arReady),
  .rValid(rValid), .rReady(rReady),
  .dropErr(dropErr), .earlyRespErr(earlyRespErr), .stallFlag(stallFlag),
  .overflowErr(overflowErr), .anyErr(anyErr)
);

// File: tb/sim_hs_dep_monitor.sv
`timescale 1ns/100ps
module sim_hs_dep_monitor;
  logic clk = 1'b0;
  logic rstN, clearErr, wLast;
  logic [15:0] stallLimit;
  logic [4:0] vv, rr;
  logic [4:0] dropErr, stallFlag;
  logic earlyRespErr, overflowErr, anyErr;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  hs_dep_monitor u0 (
    .clk(clk), .rstN(rstN), .clearErr(clearErr), .stallLimit(stallLimit),
    .awValid(vv[0]), .awReady(rr[0]), .wValid(vv[1]), .wReady(rr[1]), .wLast(wLast),
    .bValid(vv[2]), .bReady(rr[2]), .arValid(vv[3]), .arReady(rr[3]),
    .rValid(vv[4]), .rReady(rr[4]),
    .dropErr(dropErr), .earlyRespErr(earlyRespErr), .stallFlag(stallFlag),
    .overflowErr(overflowErr), .anyErr(anyErr)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    vv = '0; rr = '0; wLast = 1'b0; clearErr = 1'b0; rstN = 1'b0;
    tick(); tick();
    rstN = 1'b1;
  endtask

  task automatic fireCh(int c, logic last);
    vv = '0; rr = '0; vv[c] = 1'b1; rr[c] = 1'b1; wLast = last;
    tick();
    vv = '0; rr = '0; wLast = 1'b0;
  endtask

  task automatic clrAll();
    clearErr = 1'b1; tick(); clearErr = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    stallLimit = 16'd20;
    doReset();
    tick();
    // R9: reset state
    chk("R9 reset dropErr", dropErr, 0);
    chk("R9 reset stallFlag", stallFlag, 0);
    chk("R9 reset early", earlyRespErr, 0);
    chk("R8 reset anyErr", anyErr, 0);

    // R1: dropped VALID per channel, then clear (R7, R8)
    for (int c = 0; c < 5; c++) begin
      doReset();
      vv[c] = 1'b1; tick();
      vv = '0; tick();
      chk($sformatf("R1 drop ch%0d", c), dropErr, 1 << c);
      chk("R8 anyErr set", anyErr, 1);
      clrAll();
      chk("R7 cleared", dropErr, 0);
      chk("R8 anyErr clear", anyErr, 0);
      // legal: valid falls after handshake
      vv[c] = 1'b1; tick();
      rr[c] = 1'b1; tick();
      vv = '0; rr = '0; tick();
      chk($sformatf("R1 legal ch%0d", c), dropErr, 0);
    end

    // R5: stall sweep over limits and channels
    for (int lim = 0; lim < 4; lim++) begin
      for (int c = 0; c < 5; c++) begin
        doReset();
        stallLimit = 16'(lim);
        vv[c] = 1'b1;
        repeat (lim) tick();
        chk($sformatf("R5 below lim=%0d ch%0d", lim, c), stallFlag, 0);
        tick();
        chk($sformatf("R5 over lim=%0d ch%0d", lim, c), stallFlag, 1 << c);
        rr[c] = 1'b1; tick();
        vv = '0; rr = '0; tick();
        chk("R1 no drop after stall", dropErr, 0);
      end
    end

    // R5: counter restarts on handshake
    doReset();
    stallLimit = 16'd3;
    vv[3] = 1'b1;
    repeat (3) tick();
    rr[3] = 1'b1; tick(); rr[3] = 1'b0;
    repeat (3) tick();
    chk("R5 restart below", stallFlag, 0);
    tick();
    chk("R5 restart over", stallFlag, 5'b01000);
    stallLimit = 16'd20;
    rr[3] = 1'b1; tick(); vv = '0; rr = '0;

    // R2: B after AW only
    doReset();
    fireCh(0, 1'b0); fireCh(2, 1'b0);
    chk("R2 B after AW only", earlyRespErr, 1);
    // R2: B after WLAST only
    doReset();
    fireCh(1, 1'b1); fireCh(2, 1'b0);
    chk("R2 B after WLAST only", earlyRespErr, 1);
    // R3: data before address is legal
    doReset();
    fireCh(1, 1'b0); fireCh(1, 1'b1); fireCh(0, 1'b0); fireCh(2, 1'b0);
    chk("R3 W before AW", earlyRespErr, 0);
    // R3: non-last beat does not count
    doReset();
    fireCh(0, 1'b0); fireCh(1, 1'b0); fireCh(2, 1'b0);
    chk("R3 non-last W", earlyRespErr, 1);
    // R2: AW in same cycle as BVALID does not qualify it
    doReset();
    fireCh(1, 1'b1);
    vv = 5'b00101; rr = 5'b00101; tick(); vv = '0; rr = '0;
    chk("R2 AW same cycle as B", earlyRespErr, 1);

    // R4: AW, WLAST and B handshakes in one cycle
    doReset();
    fireCh(0, 1'b0); fireCh(1, 1'b1);
    vv = 5'b00111; rr = 5'b00111; wLast = 1'b1; tick();
    vv = '0; rr = '0; wLast = 1'b0;
    chk("R4 coincident legal", earlyRespErr, 0);
    fireCh(2, 1'b0);
    chk("R4 one left", earlyRespErr, 0);
    fireCh(2, 1'b0);
    chk("R4 none left", earlyRespErr, 1);

    // R6: overflow saturates rather than wraps
    doReset();
    repeat (15) fireCh(0, 1'b0);
    chk("R6 at max no ovf", overflowErr, 0);
    fireCh(0, 1'b0);
    chk("R6 ovf set", overflowErr, 1);
    repeat (15) fireCh(1, 1'b1);
    repeat (15) fireCh(2, 1'b0);
    chk("R6 held at 15", earlyRespErr, 0);
    fireCh(2, 1'b0);
    chk("R6 drained", earlyRespErr, 1);

    // R7: event during clear keeps flag
    doReset();
    vv[0] = 1'b1; tick();
    vv = '0; clearErr = 1'b1; tick(); clearErr = 1'b0;
    chk("R7 event wins clear", dropErr, 1);
    clrAll();
    chk("R7 clear idle", dropErr, 0);

    // R9: activity during reset is ignored
    rstN = 1'b0;
    vv = 5'b00001; tick();
    vv = '0; tick();
    vv = 5'b00011; rr = 5'b00011; wLast = 1'b1; tick();
    vv = '0; rr = '0; wLast = 1'b0;
    chk("R9 flags in reset", anyErr, 0);
    rstN = 1'b1; tick();
    chk("R9 no drop after reset", dropErr, 0);
    fireCh(2, 1'b0);
    chk("R9 counts zeroed", earlyRespErr, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule